// File: doc/BRIEF.md
# Multicast Write-Update Packet Engine

This block sits behind a coherence directory. When a write hits a cache line that several first-level caches hold, the directory gives the engine one job. The job carries the line index, the position of the first modified word, between 1 and 8 modified words each with its own byte-enable mask, the set of caches that hold a copy, and the identity of the writer. The engine gives the job a transaction slot. It then sends one command packet to each holder except the writer, over a request channel with a valid/ready handshake. Each packet is addressed to the fixed update register of the receiving cache.

Every target answers with a single-flit response tagged with the transaction ID. Each slot has its own counter of outstanding responses. When a slot's counter reaches zero, the engine reports completion for that ID and frees the slot. Several transactions can wait for their responses at once, and they may complete in any order. Only one packet stream is sent at a time.

Top module: `mcast_update_engine`

## Requirements
- R1: One packet goes to each target whose bit is set in the target mask, except the writer. Packets are sent in ascending target number on `cmd_dest`. A job whose only target is the writer sends no flit.
- R2: A packet with N modified words is N+2 flits long. `cmd_eop` is 1 on the last flit only.
- R3: On every flit, `cmd_addr` equals the parameter `UPD_ADDR` (default 0x10), `cmd_cmd` is 2'b10 (write), `cmd_plen` is 4*N and `cmd_trdid` is the job's slot number.
- R4: Flit 0 has `cmd_wdata` = line[31:0] and `cmd_be` = {2'b00, line[33:32]}.
- R5: Flit 1 has `cmd_wdata` = the first-word index, zero-extended, and `cmd_be` = 4'hF.
- R6: Flit k+2, for k from 0 to N-1, has `cmd_wdata` = `job_data[32k+:32]` and `cmd_be` = `job_be[4k+:4]`. An all-zero byte-enable value is passed through unchanged.
- R7: A job takes the lowest-numbered free slot. `job_ready` is 0 while a packet stream is being sent and while every slot is busy.
- R8: In the cycle after the edge that takes a slot's last expected response, `done_valid` is 1 for exactly one cycle with `done_trdid` set to that slot. A job that sends no packet completes in the cycle after it is accepted. After completion the slot can be reused.
- R9: While `cmd_valid` is 1 and `cmd_ready` is 0, the flit stays presented and its fields do not change.
- R10: After reset, `job_ready` is 1, `cmd_valid` is 0 and `done_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| job_valid | input | 1 | Job offered |
| job_ready | output | 1 | Job can be accepted |
| job_line | input | 34 | Cache line index |
| job_first | input | 3 | Index of the first modified word |
| job_nwords | input | 4 | Number of modified words (1 to 8) |
| job_data | input | 256 | Modified words, word k at bits [32k+31:32k] |
| job_be | input | 32 | Per-word byte enables, word k at bits [4k+3:4k] |
| job_targets | input | 8 | One bit per cache holding a copy |
| job_writer | input | 3 | Cache that issued the write |
| cmd_valid | output | 1 | Command flit valid |
| cmd_ready | input | 1 | Command flit accepted |
| cmd_addr | output | 32 | Fixed update register address |
| cmd_cmd | output | 2 | Command code, write = 2'b10 |
| cmd_plen | output | 6 | Payload length in bytes, 4*N |
| cmd_trdid | output | 2 | Transaction slot |
| cmd_dest | output | 3 | Target cache |
| cmd_wdata | output | 32 | Flit data |
| cmd_be | output | 4 | Flit byte enables |
| cmd_eop | output | 1 | Last flit of the packet |
| rsp_valid | input | 1 | Response received |
| rsp_trdid | input | 2 | Transaction slot of the response |
| done_valid | output | 1 | Transaction complete |
| done_trdid | output | 2 | Slot that completed |

## Verification
The bench tests these corner cases:
- **Writer in the target mask.** A design that did not mask out the writer would send the writer its own update.
- **Writer as the only target.** An engine that waited for a response here would hold the slot forever.
- **All slots busy.** An engine that took one more job would overwrite a live counter.
- **Out-of-order completion.** The bench completes a middle slot first. A design that released slots in order would report the wrong ID.
- **Slot reuse.** A design that did not free the completed slot would not hand it to the next job.
- **Maximum payload.** A job with eight words and seven targets catches an end-of-packet flag or length field that is off by one.
- **Zero byte-enable word.** A word whose mask is all zero catches a design that drops or alters it.
- **Back-pressure.** Alternating ready catches a flit that changes while stalled.

// File: rtl/mcast_update_engine.sv
module mcast_update_engine #(
  parameter int NTGT   = 8,
  parameter int NSLOT  = 4,
  parameter int MAXW   = 8,
  parameter int DW     = 32,
  parameter int LINE_W = 34,
  parameter int AW     = 32,
  parameter logic [AW-1:0] UPD_ADDR = 32'h0000_0010,
  localparam int BW = DW / 8,
  localparam int TW = $clog2(NTGT),
  localparam int SW = $clog2(NSLOT),
  localparam int IW = $clog2(MAXW),
  localparam int NW = $clog2(MAXW + 1),
  localparam int PW = $clog2(4 * MAXW + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               job_valid,
  output logic               job_ready,
  input  logic [LINE_W-1:0]  job_line,
  input  logic [IW-1:0]      job_first,
  input  logic [NW-1:0]      job_nwords,
  input  logic [MAXW*DW-1:0] job_data,
  input  logic [MAXW*BW-1:0] job_be,
  input  logic [NTGT-1:0]    job_targets,
  input  logic [TW-1:0]      job_writer,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [AW-1:0]      cmd_addr,
  output logic [1:0]         cmd_cmd,
  output logic [PW-1:0]      cmd_plen,
  output logic [SW-1:0]      cmd_trdid,
  output logic [TW-1:0]      cmd_dest,
  output logic [DW-1:0]      cmd_wdata,
  output logic [BW-1:0]      cmd_be,
  output logic               cmd_eop,
  input  logic               rsp_valid,
  input  logic [SW-1:0]      rsp_trdid,
  output logic               done_valid,
  output logic [SW-1:0]      done_trdid
);
  localparam int FW = $clog2(MAXW + 2);
  localparam int CW = $clog2(NTGT + 1);
  localparam int HW = LINE_W - DW;
  localparam logic [1:0] CMD_WR = 2'b10;

  logic               sending;
  logic [LINE_W-1:0]  line_q;
  logic [IW-1:0]      first_q;
  logic [NW-1:0]      n_q;
  logic [MAXW*DW-1:0] data_q;
  logic [MAXW*BW-1:0] be_q;
  logic [NTGT-1:0]    left_q;
  logic [TW-1:0]      wr_q;
  logic [SW-1:0]      slot_q;
  logic [FW-1:0]      flit_q;
  logic [NSLOT-1:0]   busy;
  logic [CW-1:0]      pend [NSLOT];

  logic              free_found;
  logic [SW-1:0]     free_idx;
  logic [TW-1:0]     cur_tgt;
  logic [NTGT-1:0]   mask_in;
  logic              accept, fire, last;
  logic [IW-1:0]     wsel;

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = NSLOT - 1; i >= 0; i--)
      if (!busy[i]) begin
        free_found = 1'b1;
        free_idx   = SW'(i);
      end
  end

  always_comb begin
    cur_tgt = '0;
    for (int i = NTGT - 1; i >= 0; i--)
      if (left_q[i]) cur_tgt = TW'(i);
  end

  always_comb begin
    done_valid = 1'b0;
    done_trdid = '0;
    for (int i = NSLOT - 1; i >= 0; i--)
      if (busy[i] && pend[i] == '0) begin
        done_valid = 1'b1;
        done_trdid = SW'(i);
      end
  end

  assign mask_in   = job_targets & ~(NTGT'(1) << job_writer);
  assign job_ready = !sending && free_found;
  assign accept    = job_valid && job_ready;
  assign fire      = cmd_valid && cmd_ready;
  assign last      = flit_q == FW'(n_q) + FW'(1);
  assign wsel      = IW'(flit_q - FW'(2));

  assign cmd_valid = sending;
  assign cmd_addr  = UPD_ADDR;
  assign cmd_cmd   = CMD_WR;
  assign cmd_plen  = PW'(n_q) << 2;
  assign cmd_trdid = slot_q;
  assign cmd_dest  = cur_tgt;
  assign cmd_eop   = last;
  assign cmd_wdata = (flit_q == '0)     ? line_q[DW-1:0] :
                     (flit_q == FW'(1)) ? DW'(first_q)   :
                                          data_q[wsel*DW +: DW];
  assign cmd_be    = (flit_q == '0)     ? BW'(line_q[LINE_W-1:LINE_W-HW]) :
                     (flit_q == FW'(1)) ? {BW{1'b1}} :
                                          be_q[wsel*BW +: BW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sending <= 1'b0;
      line_q  <= '0;
      first_q <= '0;
      n_q     <= '0;
      data_q  <= '0;
      be_q    <= '0;
      left_q  <= '0;
      wr_q    <= '0;
      slot_q  <= '0;
      flit_q  <= '0;
    end else if (accept) begin
      sending <= |mask_in;
      line_q  <= job_line;
      first_q <= job_first;
      n_q     <= job_nwords;
      data_q  <= job_data;
      be_q    <= job_be;
      left_q  <= mask_in;
      wr_q    <= job_writer;
      slot_q  <= free_idx;
      flit_q  <= '0;
    end else if (fire) begin
      if (last) begin
        flit_q          <= '0;
        left_q[cur_tgt] <= 1'b0;
        if (left_q == (NTGT'(1) << cur_tgt)) sending <= 1'b0;
      end else begin
        flit_q <= flit_q + FW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= '0;
      for (int i = 0; i < NSLOT; i++) pend[i] <= '0;
    end else begin
      if (done_valid) busy[done_trdid] <= 1'b0;
      if (rsp_valid && busy[rsp_trdid] && pend[rsp_trdid] != '0)
        pend[rsp_trdid] <= pend[rsp_trdid] - CW'(1);
      if (accept) begin
        busy[free_idx] <= 1'b1;
        pend[free_idx] <= CW'($countones(mask_in));
      end
    end
  end

  AST_NOT_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_dest != wr_q); // R1
  AST_EOP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_eop |-> cmd_plen == (PW'(flit_q) - PW'(1)) << 2); // R2
  AST_FULL_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    &busy |-> !job_ready); // R7
  AST_DONE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !(done_valid && done_trdid == $past(done_trdid))); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && busy[rsp_trdid] |-> pend[rsp_trdid] != '0); // R8
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_wdata) && $stable(cmd_be)
      && $stable(cmd_dest) && $stable(cmd_eop)); // R9
endmodule

// File: tb/mcast_update_engine_bench.sv
module mcast_update_engine_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic         job_valid = 1'b0, job_ready;
  logic [33:0]  job_line = '0;
  logic [2:0]   job_first = '0;
  logic [3:0]   job_nwords = 4'd1;
  logic [255:0] job_data = '0;
  logic [31:0]  job_be = '0;
  logic [7:0]   job_targets = '0;
  logic [2:0]   job_writer = '0;
  logic         cmd_valid, cmd_ready = 1'b1, cmd_eop;
  logic [31:0]  cmd_addr, cmd_wdata;
  logic [1:0]   cmd_cmd, cmd_trdid;
  logic [5:0]   cmd_plen;
  logic [2:0]   cmd_dest;
  logic [3:0]   cmd_be;
  logic         rsp_valid = 1'b0;
  logic [1:0]   rsp_trdid = '0;
  logic         done_valid;
  logic [1:0]   done_trdid;

  mcast_update_engine u_mcast_update_engine (
    .clk, .rst_n, .job_valid, .job_ready, .job_line, .job_first, .job_nwords,
    .job_data, .job_be, .job_targets, .job_writer, .cmd_valid, .cmd_ready,
    .cmd_addr, .cmd_cmd, .cmd_plen, .cmd_trdid, .cmd_dest, .cmd_wdata, .cmd_be,
    .cmd_eop, .rsp_valid, .rsp_trdid, .done_valid, .done_trdid);

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  bit stall_mode = 1'b0;

  logic [31:0] lg_wdata [512];
  logic [3:0]  lg_be    [512];
  logic [2:0]  lg_dest  [512];
  logic        lg_eop   [512];
  logic [1:0]  lg_trd   [512];
  logic [5:0]  lg_plen  [512];
  logic [31:0] lg_addr  [512];
  logic [1:0]  lg_cmd   [512];
  int          lg_n = 0;
  logic [1:0]  dn_trd   [64];
  int          dn_n = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc <= cyc + 1;
    cmd_ready <= stall_mode ? (cyc[0] ^ cyc[2]) : 1'b1;
  end

  logic        pv = 1'b0, pr = 1'b0, pe = 1'b0;
  logic [31:0] pd = '0;
  logic [3:0]  pb = '0;
  logic [2:0]  pt = '0;
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (pv && !pr) begin
        chk(cmd_valid && cmd_wdata == pd && cmd_be == pb && cmd_dest == pt && cmd_eop == pe,
            "R9", "stalled flit held", {cmd_valid, cmd_wdata}, {1'b1, pd});
      end
      if (cmd_valid && cmd_ready && lg_n < 512) begin
        lg_wdata[lg_n] = cmd_wdata; lg_be[lg_n] = cmd_be; lg_dest[lg_n] = cmd_dest;
        lg_eop[lg_n] = cmd_eop; lg_trd[lg_n] = cmd_trdid; lg_plen[lg_n] = cmd_plen;
        lg_addr[lg_n] = cmd_addr; lg_cmd[lg_n] = cmd_cmd;
        lg_n++;
      end
      if (done_valid && dn_n < 64) begin
        dn_trd[dn_n] = done_trdid;
        dn_n++;
      end
      pv = cmd_valid; pr = cmd_ready; pd = cmd_wdata; pb = cmd_be; pt = cmd_dest; pe = cmd_eop;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle();
    do begin @(negedge clk); #2; end while (cmd_valid);
    @(negedge clk);
  endtask

  task automatic submit(input logic [33:0] line, input logic [2:0] first, input logic [3:0] n,
                        input logic [255:0] dat, input logic [31:0] bes,
                        input logic [7:0] tg, input logic [2:0] wr);
    @(negedge clk);
    job_valid = 1'b1; job_line = line; job_first = first; job_nwords = n;
    job_data = dat; job_be = bes; job_targets = tg; job_writer = wr;
    forever begin
      #2;
      if (job_ready) break;
      @(negedge clk);
    end
    @(negedge clk);
    job_valid = 1'b0;
  endtask

  task automatic respond(input logic [1:0] trd);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_trdid = trd;
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic check_pkt(input int s, input logic [2:0] dst, input logic [1:0] trd,
                           input logic [33:0] line, input logic [2:0] first, input int n,
                           input logic [255:0] dat, input logic [31:0] bes);
    for (int f = 0; f < n + 2; f++) begin
      logic [31:0] ew;
      logic [3:0]  eb;
      if (f == 0) begin ew = line[31:0]; eb = {2'b00, line[33:32]}; end
      else if (f == 1) begin ew = {29'd0, first}; eb = 4'hF; end
      else begin ew = dat[(f-2)*32 +: 32]; eb = bes[(f-2)*4 +: 4]; end
      if (f == 0) chk(lg_wdata[s+f] == ew && lg_be[s+f] == eb, "R4", "header flit", {lg_be[s+f], lg_wdata[s+f]}, {eb, ew});
      else if (f == 1) chk(lg_wdata[s+f] == ew && lg_be[s+f] == eb, "R5", "start-word flit", {lg_be[s+f], lg_wdata[s+f]}, {eb, ew});
      else chk(lg_wdata[s+f] == ew && lg_be[s+f] == eb, "R6", "data flit", {lg_be[s+f], lg_wdata[s+f]}, {eb, ew});
      chk(lg_eop[s+f] == (f == n + 1), "R2", "end marker", lg_eop[s+f], f == n + 1);
      chk(lg_dest[s+f] == dst, "R1", "destination", lg_dest[s+f], dst);
      chk(lg_addr[s+f] == 32'h10 && lg_cmd[s+f] == 2'b10 && lg_plen[s+f] == 6'(4*n) && lg_trd[s+f] == trd,
          "R3", "addr/cmd/plen/trdid", {lg_addr[s+f], lg_cmd[s+f], lg_plen[s+f], lg_trd[s+f]},
          {32'h10, 2'b10, 6'(4*n), trd});
    end
  endtask

  task automatic check_job(input int s, input logic [7:0] tg, input logic [2:0] wr,
                           input logic [1:0] trd, input logic [33:0] line, input logic [2:0] first,
                           input int n, input logic [255:0] dat, input logic [31:0] bes);
    int p = s;
    for (int t = 0; t < 8; t++)
      if (tg[t] && t != int'(wr)) begin
        check_pkt(p, 3'(t), trd, line, first, n, dat, bes);
        p += n + 2;
      end
    chk(lg_n == p, "R1", "flit count of job", lg_n, p);
  endtask

  task automatic t_reset();
    @(negedge clk); #2;
    chk(job_ready == 1'b1, "R10", "job_ready after reset", job_ready, 1);
    chk(cmd_valid == 1'b0, "R10", "cmd_valid after reset", cmd_valid, 0);
    chk(done_valid == 1'b0, "R10", "done_valid after reset", done_valid, 0);
  endtask

  task automatic t_basic();
    logic [255:0] d = '0;
    logic [31:0]  b = '0;
    int s = lg_n, dn0 = dn_n;
    for (int k = 0; k < 3; k++) d[k*32 +: 32] = 32'hA5000000 + 32'(k * 17);
    b[3:0] = 4'h3; b[7:4] = 4'h0; b[11:8] = 4'hC;
    submit(34'h2_DEAD_BEEF, 3'd5, 4'd3, d, b, 8'b0010_0110, 3'd2);
    wait_idle();
    check_job(s, 8'b0010_0110, 3'd2, 2'd0, 34'h2_DEAD_BEEF, 3'd5, 3, d, b);
    respond(2'd0);
    wait_cyc(2);
    chk(dn_n == dn0, "R8", "no completion after one of two responses", dn_n, dn0);
    respond(2'd0);
    wait_cyc(2);
    chk(dn_n == dn0 + 1, "R8", "one completion", dn_n, dn0 + 1);
    chk(dn_trd[dn0] == 2'd0, "R8", "completed trdid", dn_trd[dn0], 0);
  endtask

  task automatic t_empty();
    int s = lg_n, dn0 = dn_n;
    submit(34'h1_0000_0042, 3'd1, 4'd2, '1, '1, 8'b0001_0000, 3'd4);
    wait_cyc(3);
    chk(lg_n == s, "R1", "no flit for writer-only job", lg_n, s);
    chk(dn_n == dn0 + 1, "R8", "immediate completion", dn_n, dn0 + 1);
    chk(dn_trd[dn0] == 2'd0, "R8", "immediate completion trdid", dn_trd[dn0], 0);
  endtask

  task automatic t_full();
    int dn0 = dn_n;
    int s;
    for (int j = 0; j < 4; j++) begin
      s = lg_n;
      submit(34'(j + 100), 3'(j), 4'd1, 256'(32'h1111 * (j + 1)), 32'hF, 8'(1 << (j + 1)), 3'd0);
      wait_idle();
      check_job(s, 8'(1 << (j + 1)), 3'd0, 2'(j), 34'(j + 100), 3'(j), 1,
                256'(32'h1111 * (j + 1)), 32'hF);
    end
    @(negedge clk); #2;
    chk(job_ready == 1'b0, "R7", "refused while all slots busy", job_ready, 0);
    respond(2'd2);
    wait_cyc(2);
    chk(dn_n == dn0 + 1 && dn_trd[dn0] == 2'd2, "R8", "out-of-order completion", dn_trd[dn0], 2);
    s = lg_n;
    submit(34'h3_0000_0007, 3'd7, 4'd1, 256'h77, 32'h0, 8'b1000_0000, 3'd1);
    wait_idle();
    check_job(s, 8'b1000_0000, 3'd1, 2'd2, 34'h3_0000_0007, 3'd7, 1, 256'h77, 32'h0);
    respond(2'd0); respond(2'd1); respond(2'd3); respond(2'd2);
    wait_cyc(3);
    chk(dn_n == dn0 + 5, "R8", "all slots completed", dn_n, dn0 + 5);
    @(negedge clk); #2;
    chk(job_ready == 1'b1, "R7", "ready after slots freed", job_ready, 1);
  endtask

  task automatic t_max_stall();
    logic [255:0] d = '0;
    logic [31:0]  b = '0;
    int s = lg_n, dn0 = dn_n;
    for (int k = 0; k < 8; k++) begin
      d[k*32 +: 32] = 32'h0BAD0000 ^ 32'(k * 32'h01010101);
      b[k*4 +: 4] = 4'(k * 5);
    end
    stall_mode = 1'b1;
    submit(34'h3_FFFF_FFFF, 3'd0, 4'd8, d, b, 8'hFF, 3'd0);
    wait_idle();
    stall_mode = 1'b0;
    check_job(s, 8'hFF, 3'd0, 2'd0, 34'h3_FFFF_FFFF, 3'd0, 8, d, b);
    for (int r = 0; r < 7; r++) respond(2'd0);
    wait_cyc(3);
    chk(dn_n == dn0 + 1 && dn_trd[dn0] == 2'd0, "R8", "completion after seven responses", dn_n, dn0 + 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_empty();
    t_full();
    t_max_stall();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule